// File: doc/BRIEF.md
# Stateful Bus Reference Monitor

This block stands between two bus masters and a shared bus and decides, request by request, whether an access may go through. Each request carries a master identifier, a 32-bit address, a write flag and write data. The block matches the address against ten fixed inclusive windows. It then looks up whether the requesting master may use any window that matched, and the answer depends on a small ownership state held inside the block.

Two control-word windows act as a lock on a shared crypto peripheral. A master that writes the "claim" word while nobody holds the lock becomes the owner. From the next request onward, that master alone may reach the crypto register window and its control word. When the owner writes the "release" word, the lock is freed again.

Every granted request is repeated on the forward side one clock later, with all fields unchanged. A refused request is never forwarded. Instead it raises a one-cycle error pulse back to the requester. The first refused request also sets a sticky violation flag and records its master and address. The flag and the record hold until a synchronous reset.

Top module: `bus_ref_monitor`

## Requirements
- R1: Master encoding is `req_master` 0 for master A and 1 for master B. The inclusive windows are:
  - W0 debug 0x41400000–0x4140FFFF
  - W1 crypto registers 0x28000000–0x28000777
  - W2 crypto bank 0x28000800–0x28000FFF
  - W3 memory A 0x24000000–0x24777777
  - W4 memory B 0x24800000–0x24FFFFFF
  - W5 serial 0x40600000–0x4060FFFF
  - W6 network 0x40C00000–0x40C0FFFF
  - W7 claim word 0x28000004–0x28000007
  - W8 release word 0x28000008–0x2800000F
  - W9 crypto control word 0x28000000–0x28000003
- R2: A granted request in cycle t appears on `fwd_valid` in cycle t+1, with master, address, write flag and data copied unchanged.
- R3: The base grants hold in every state, for reads and writes:
  - master A may use W0, W3 and W5;
  - master B may use W0, W4 and W6.
- R4: A refused request is not forwarded. It raises `err_valid` in the next cycle with `err_master` equal to the requester, and `fwd_valid` and `err_valid` are never high together.
- R5: An address in none of the ten windows is always refused, for both masters and both directions. W2 is granted to no master.
- R6: In the free state, an accepted write to W7 makes the writer the owner. While a master owns the lock, that master, and only that master, may read and write W1 and W9. Ownership never passes directly from one master to the other.
- R7: An accepted write to W8 by the owner frees the lock. W8 writes by the non-owner, W7 writes while the lock is held, and W8 writes in the free state leave the state unchanged.
- R8: Both masters may always read and write W7 and W8. Only writes act as triggers, and a state change applies from the next request on.
- R9: When windows overlap (W7, W8 and W9 lie inside W1), a request is granted if any window it matches grants it.
- R10: The first refused request sets `viol_flag` and records `viol_master` and `viol_addr`. Later refusals do not change them. Only reset clears them.
- R11: After synchronous reset, `fwd_valid`, `err_valid` and `viol_flag` are low and the lock is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 1 | Requester: 0 master A, 1 master B |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| fwd_valid | output | 1 | Granted request forwarded |
| fwd_master | output | 1 | Forwarded requester |
| fwd_addr | output | 32 | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_wdata | output | 32 | Forwarded write data |
| err_valid | output | 1 | Error response for a refused request |
| err_master | output | 1 | Master receiving the error |
| viol_flag | output | 1 | Sticky violation indicator |
| viol_master | output | 1 | Master of the first violation |
| viol_addr | output | 32 | Address of the first violation |

## Verification
Random requests are drawn mostly from inside the ten windows, with a share of arbitrary addresses. This separates window decoding from the permission lookup. Directed sequences step the lock through claim, foreign claim, foreign release, trigger reads and owner release, and probe W1 and W9 after each step, which isolates the state machine from the base grants. Boundary addresses just inside and just outside W3, W1 and the W3–W4 gap check the inclusive limits. A mid-run reset followed by a fresh violation shows that the sticky record clears and recaptures.

// File: rtl/bus_rm_pkg.sv
package bus_rm_pkg;

  localparam int NUM_WIN = 10;

  // Window indices; W7 and W8 are decoded by the lock state machine
  localparam int W_DEBUG   = 0;
  localparam int W_CRYPTO  = 1;
  localparam int W_BANK    = 2;
  localparam int W_MEMA    = 3;
  localparam int W_MEMB    = 4;
  localparam int W_SERIAL  = 5;
  localparam int W_NET     = 6;
  localparam int W_CLAIM   = 7;
  localparam int W_RELEASE = 8;
  localparam int W_CCTL    = 9;

  typedef enum logic [1:0] {
    LOCK_FREE = 2'd0,
    LOCK_A    = 2'd1,
    LOCK_B    = 2'd2
  } lock_state_e;

  function automatic logic [31:0] win_lo(input int idx);
    case (idx)
      W_DEBUG:   return 32'h4140_0000;
      W_CRYPTO:  return 32'h2800_0000;
      W_BANK:    return 32'h2800_0800;
      W_MEMA:    return 32'h2400_0000;
      W_MEMB:    return 32'h2480_0000;
      W_SERIAL:  return 32'h4060_0000;
      W_NET:     return 32'h40C0_0000;
      W_CLAIM:   return 32'h2800_0004;
      W_RELEASE: return 32'h2800_0008;
      W_CCTL:    return 32'h2800_0000;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] win_hi(input int idx);
    case (idx)
      W_DEBUG:   return 32'h4140_FFFF;
      W_CRYPTO:  return 32'h2800_0777;
      W_BANK:    return 32'h2800_0FFF;
      W_MEMA:    return 32'h2477_7777;
      W_MEMB:    return 32'h24FF_FFFF;
      W_SERIAL:  return 32'h4060_FFFF;
      W_NET:     return 32'h40C0_FFFF;
      W_CLAIM:   return 32'h2800_0007;
      W_RELEASE: return 32'h2800_000F;
      W_CCTL:    return 32'h2800_0003;
      default:   return 32'h0000_0000;
    endcase
  endfunction

  // Grant of one window to one master under one lock state (read or write alike)
  function automatic logic win_grant(input int idx, input logic mst, input lock_state_e st);
    case (idx)
      W_DEBUG:             return 1'b1;
      W_MEMA, W_SERIAL:    return ~mst;
      W_MEMB, W_NET:       return mst;
      W_CLAIM, W_RELEASE:  return 1'b1;
      W_CRYPTO, W_CCTL:    return (st == LOCK_A && !mst) || (st == LOCK_B && mst);
      default:             return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rm_window_decode.sv
module rm_window_decode
  import bus_rm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_WIN  = NUM_WIN
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_WIN-1:0]  hit
);

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(win_lo(g));
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(win_hi(g));
    assign hit[g] = (addr >= LO) && (addr <= HI);
  end

endmodule

// File: rtl/rm_perm_check.sv
module rm_perm_check
  import bus_rm_pkg::*;
#(
  parameter int N_WIN = NUM_WIN
) (
  input  logic [N_WIN-1:0] hit,
  input  logic             master,
  input  logic             write,
  input  lock_state_e      state,
  output logic             allow,
  output logic             claim,
  output logic             release_wr
);

  logic [N_WIN-1:0] grant;

  for (genvar g = 0; g < N_WIN; g++) begin : g_grant
    assign grant[g] = hit[g] & win_grant(g, master, state);
  end

  // Any matching window that grants is enough (overlaps resolved by OR)
  assign allow      = |grant;
  assign claim      = write & hit[W_CLAIM];
  assign release_wr = write & hit[W_RELEASE];

  always_comb begin
    if (hit == '0) begin
      assert_outside_denied_R5: assert (!allow);
    end
    if (hit[W_CLAIM] || hit[W_RELEASE]) begin
      assert_trigger_open_R8: assert (allow);
    end
  end

endmodule

// File: rtl/rm_lock_fsm.sv
module rm_lock_fsm
  import bus_rm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_en,
  input  logic        master,
  input  logic        claim,
  input  logic        release_wr,
  output lock_state_e state
);

  lock_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      LOCK_FREE: if (acc_en && claim) nxt = master ? LOCK_B : LOCK_A;
      LOCK_A:    if (acc_en && release_wr && !master) nxt = LOCK_FREE;
      LOCK_B:    if (acc_en && release_wr && master) nxt = LOCK_FREE;
      default:   nxt = LOCK_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LOCK_FREE;
    else     state <= nxt;
  end

  assert_no_handover_a_R6: assert property (@(posedge clk) disable iff (rst)
    (state == LOCK_A) |-> ($past(state) != LOCK_B));
  assert_no_handover_b_R6: assert property (@(posedge clk) disable iff (rst)
    (state == LOCK_B) |-> ($past(state) != LOCK_A));
  assert_release_by_owner_R7: assert property (@(posedge clk) disable iff (rst)
    (state == LOCK_FREE && $past(state) == LOCK_A) |-> ($past(release_wr) && !$past(master)));
  assert_claim_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    (state != LOCK_FREE && $past(state) == LOCK_FREE) |-> ($past(acc_en) && $past(claim)));

endmodule

// File: rtl/bus_ref_monitor.sv
module bus_ref_monitor
  import bus_rm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_master,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fwd_valid,
  output logic              fwd_master,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              err_valid,
  output logic              err_master,
  output logic              viol_flag,
  output logic              viol_master,
  output logic [ADDR_W-1:0] viol_addr
);

  localparam int N_WIN = NUM_WIN;

  logic [N_WIN-1:0] hit;
  logic             allow;
  logic             claim;
  logic             release_wr;
  lock_state_e      state;

  rm_window_decode #(.ADDR_W(ADDR_W), .N_WIN(N_WIN)) u_decode (
    .addr (req_addr),
    .hit  (hit)
  );

  rm_perm_check #(.N_WIN(N_WIN)) u_perm (
    .hit        (hit),
    .master     (req_master),
    .write      (req_write),
    .state      (state),
    .allow      (allow),
    .claim      (claim),
    .release_wr (release_wr)
  );

  rm_lock_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (req_valid & allow),
    .master     (req_master),
    .claim      (claim),
    .release_wr (release_wr),
    .state      (state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid   <= 1'b0;
      fwd_master  <= 1'b0;
      fwd_addr    <= '0;
      fwd_write   <= 1'b0;
      fwd_wdata   <= '0;
      err_valid   <= 1'b0;
      err_master  <= 1'b0;
      viol_flag   <= 1'b0;
      viol_master <= 1'b0;
      viol_addr   <= '0;
    end else begin
      fwd_valid <= req_valid & allow;
      err_valid <= req_valid & ~allow;
      if (req_valid) begin
        fwd_master <= req_master;
        fwd_addr   <= req_addr;
        fwd_write  <= req_write;
        fwd_wdata  <= req_wdata;
        err_master <= req_master;
      end
      if (req_valid && !allow && !viol_flag) begin
        viol_flag   <= 1'b1;
        viol_master <= req_master;
        viol_addr   <= req_addr;
      end
    end
  end

  assert_fwd_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(fwd_valid && err_valid));
  assert_fwd_latency_R2: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> ($past(req_valid) && fwd_addr == $past(req_addr)));
  assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    viol_flag |=> (viol_flag && $stable(viol_addr) && $stable(viol_master)));
  assert_err_with_viol_R10: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> viol_flag);

endmodule

// File: tb/bus_ref_monitor_bench.sv
module bus_ref_monitor_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_master = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        fwd_valid, fwd_master, fwd_write;
  logic [31:0] fwd_addr, fwd_wdata;
  logic        err_valid, err_master;
  logic        viol_flag, viol_master;
  logic [31:0] viol_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state: 0 free, 1 master A owns, 2 master B owns
  int          m_state = 0;
  bit          m_viol = 0;
  logic        m_vmst = 0;
  logic [31:0] m_vaddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_ref_monitor u_bus_ref_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .fwd_valid(fwd_valid), .fwd_master(fwd_master), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .fwd_wdata(fwd_wdata), .err_valid(err_valid),
    .err_master(err_master), .viol_flag(viol_flag), .viol_master(viol_master),
    .viol_addr(viol_addr)
  );

  function automatic logic [31:0] b_lo(input int i);
    case (i)
      0: return 32'h41400000; 1: return 32'h28000000; 2: return 32'h28000800;
      3: return 32'h24000000; 4: return 32'h24800000; 5: return 32'h40600000;
      6: return 32'h40C00000; 7: return 32'h28000004; 8: return 32'h28000008;
      default: return 32'h28000000;
    endcase
  endfunction

  function automatic logic [31:0] b_hi(input int i);
    case (i)
      0: return 32'h4140FFFF; 1: return 32'h28000777; 2: return 32'h28000FFF;
      3: return 32'h24777777; 4: return 32'h24FFFFFF; 5: return 32'h4060FFFF;
      6: return 32'h40C0FFFF; 7: return 32'h28000007; 8: return 32'h2800000F;
      default: return 32'h28000003;
    endcase
  endfunction

  function automatic bit in_w(input int i, input logic [31:0] a);
    return (a >= b_lo(i)) && (a <= b_hi(i));
  endfunction

  function automatic bit model_allow(input logic m, input logic [31:0] a);
    bit ok = 0;
    bit owner = (m_state == 1 && !m) || (m_state == 2 && m);
    if (in_w(0, a) || in_w(7, a) || in_w(8, a)) ok = 1;
    if (!m && (in_w(3, a) || in_w(5, a))) ok = 1;
    if (m && (in_w(4, a) || in_w(6, a))) ok = 1;
    if (owner && (in_w(1, a) || in_w(9, a))) ok = 1;
    return ok;
  endfunction

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_viol(input string tag);
    check(viol_flag == m_viol, tag, "viol_flag", 32'(viol_flag), 32'(m_viol));
    if (m_viol) begin
      check(viol_master == m_vmst, tag, "viol_master", 32'(viol_master), 32'(m_vmst));
      check(viol_addr == m_vaddr, tag, "viol_addr", viol_addr, m_vaddr);
    end
  endtask

  // Drive one request at a falling edge, sample the registered result one cycle on.
  // want: -1 model only, 0 expect refusal, 1 expect grant
  task automatic do_req(input logic m, input logic [31:0] a, input logic w,
                        input int want, input string tag);
    logic [31:0] d = $urandom;
    bit ex = model_allow(m, a);
    req_valid = 1'b1; req_master = m; req_addr = a; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (want >= 0)
      check(fwd_valid == want[0], tag, "directed fwd_valid", 32'(fwd_valid), 32'(want));
    check(fwd_valid == ex, tag, "fwd_valid", 32'(fwd_valid), 32'(ex));
    check(err_valid == !ex, tag, "err_valid", 32'(err_valid), 32'(!ex));
    if (ex) begin
      check(fwd_addr == a && fwd_master == m && fwd_write == w && fwd_wdata == d,
            tag, "fwd fields (addr)", fwd_addr, a);
    end else begin
      check(err_master == m, tag, "err_master", 32'(err_master), 32'(m));
      if (!m_viol) begin m_viol = 1; m_vmst = m; m_vaddr = a; end
    end
    if (ex && w) begin
      if (in_w(7, a) && m_state == 0) m_state = m ? 2 : 1;
      else if (in_w(8, a) && ((m_state == 1 && !m) || (m_state == 2 && m))) m_state = 0;
    end
    check_viol(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_state = 0; m_viol = 0;
    check(fwd_valid == 0, "R11", "fwd_valid after reset", 32'(fwd_valid), 0);
    check(err_valid == 0, "R11", "err_valid after reset", 32'(err_valid), 0);
    check(viol_flag == 0, "R11", "viol_flag after reset", 32'(viol_flag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0DE_5EED));
    @(negedge clk);
    do_reset();

    // R11 / R6: lock free after reset, crypto window closed to both
    do_req(0, 32'h28000100, 0, 0, "R11");
    do_req(1, 32'h28000000, 1, 0, "R6");
    // R3 base grants
    do_req(0, 32'h24000000, 1, 1, "R3");
    do_req(0, 32'h4060FFFF, 0, 1, "R3");
    do_req(1, 32'h24FFFFFF, 0, 1, "R3");
    do_req(1, 32'h40C00010, 1, 1, "R3");
    do_req(0, 32'h41400020, 0, 1, "R3");
    do_req(1, 32'h4140FFFF, 1, 1, "R3");
    do_req(1, 32'h24000000, 0, 0, "R3");
    do_req(0, 32'h40C00000, 0, 0, "R3");
    // R1 boundaries
    do_req(0, 32'h24777777, 0, 1, "R1");
    do_req(0, 32'h24777778, 0, 0, "R1");
    do_req(1, 32'h247FFFFF, 0, 0, "R1");
    // R5 outside and W2
    do_req(0, 32'h00000000, 1, 0, "R5");
    do_req(1, 32'hFFFFFFFF, 0, 0, "R5");
    do_req(0, 32'h28000800, 0, 0, "R5");
    // R8 trigger reads allowed but do not claim
    do_req(0, 32'h28000004, 0, 1, "R8");
    do_req(0, 32'h28000100, 0, 0, "R8");
    // R7 release in free state is no change
    do_req(1, 32'h2800000C, 1, 1, "R7");
    do_req(1, 32'h28000100, 0, 0, "R7");
    // R6 claim by A, applies from next request
    do_req(0, 32'h28000006, 1, 1, "R6");
    do_req(0, 32'h28000777, 0, 1, "R6");
    do_req(0, 32'h28000000, 1, 1, "R9");
    do_req(1, 32'h28000002, 0, 0, "R6");
    do_req(0, 32'h28000778, 0, 0, "R1");
    // R7 foreign claim and foreign release ignored
    do_req(1, 32'h28000004, 1, 1, "R7");
    do_req(1, 32'h28000010, 0, 0, "R7");
    do_req(0, 32'h28000010, 0, 1, "R7");
    do_req(1, 32'h28000008, 1, 1, "R7");
    do_req(0, 32'h28000020, 1, 1, "R7");
    // R7 owner release
    do_req(0, 32'h2800000F, 1, 1, "R7");
    do_req(0, 32'h28000020, 0, 0, "R7");
    // R6 claim by B
    do_req(1, 32'h28000007, 1, 1, "R6");
    do_req(1, 32'h28000003, 1, 1, "R9");
    do_req(0, 32'h28000003, 0, 0, "R6");
    do_req(1, 32'h28000008, 1, 1, "R7");
    // R2 idle cycle forwards nothing
    @(negedge clk);
    check(fwd_valid == 0 && err_valid == 0, "R2", "idle outputs", 32'(fwd_valid), 0);

    // R10 reset clears the record, new violation recaptured
    do_reset();
    do_req(1, 32'h12345678, 0, 0, "R10");
    do_req(0, 32'h00000010, 1, 0, "R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      int wi = $urandom_range(0, 11);
      if (wi >= 10) a = $urandom;
      else a = b_lo(wi) + ($urandom % (b_hi(wi) - b_lo(wi) + 1));
      do_req(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)), -1, "R9");
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule